// File: doc/BRIEF.md
# Multi-Match Timer Bank with Snapshot Capture

The block holds a small bank of free-running up-counters that tick on a function clock, while software reaches them over a simple single-cycle register bus on a separate bus clock. Each counter is compared against its own set of match values. Any comparator that software picks in a per-timer reload selector sends the counter back to a programmable preload value instead of letting it advance. A counter with no comparator selected simply wraps through all ones to zero.

The live count is never put on the bus. Software writes a request to a timer's capture register. The request crosses into the function clock domain, and a few cycles later the current count is copied into a snapshot. The snapshot stays frozen until the next request, so a bus read of it cannot catch a count that is changing. Every comparator hit is carried back into the bus domain and sets a sticky status bit. Status bits that software has enabled are combined into one interrupt line per timer, and software clears them by writing ones.

Top module: `mmt_timer_bank`

## Requirements
- R1: After reset every count and snapshot is 0, the enable register, clock-control register and all status bits read 0, and every interrupt line is low.
- R2: Register word addresses with three timers of three comparators: clock control 0 (8 bits kept), comparator m of timer t at 1+3t+m, preload of timer t at 10+t, reload selector at 13+t (3 bits kept), status at 16+t, interrupt enable at 19+t (3 bits kept), interrupt clear at 22+t (reads 0), enable 25 (bit t runs timer t), capture at 26+t. Stored fields read back as written, with unused bits zero.
- R3: A timer whose enable bit is 0 holds its count and raises no comparator hits.
- R4: An enabled timer that does not reload increments by exactly one per function-clock cycle.
- R5: A timer's comparator m hits in the cycle in which the running count equals its match value. That hit sets bit m of the timer's status register.
- R6: When a hitting comparator has its bit set in the reload selector (value 1 picks comparator 0), the next count is the preload value. Comparators that are not selected only report status, and the count passes them.
- R7: Writing 1 to bit 0 of a timer's capture register copies the live count into that timer's snapshot two to three function-clock cycles later. A read before then returns the previous snapshot.
- R8: A snapshot keeps its value until the next capture request of that timer completes.
- R9: Interrupt line t is high exactly when some status bit of timer t has its interrupt-enable bit set. The match_status output carries status bit m of timer t at position 3t+m.
- R10: Writing 1 to a bit of a timer's interrupt-clear register clears that status bit. A hit arriving in the same bus cycle as the clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| fn_clk | input | 1 | Function clock that drives the counters |
| rst_n | input | 1 | Asynchronous active-low reset, released per clock domain |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| match_status | output | 9 | Sticky status bits, timer-major |
| irq | output | 3 | Per-timer interrupt request |

## Verification
The checks take for granted that comparator values, preload values and reload selectors are quasi-static. Software changes them only while the timer they feed is stopped. They also assume that the hits of one comparator are at least a few function cycles apart, and that the bus clock is faster than the function clock, so that every hit toggle crosses before the next one. The stimulus programs all configuration with the timers disabled. It uses a bus clock four times the function clock, and its reload loops are three counts long. Timed comparisons of counts are made between capture requests issued at the same phase of the two clocks, so the crossing latency is identical for both requests.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  localparam int AW = 6;
  localparam int DW = 32;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_CLK,
    RG_MATCH,
    RG_PRE,
    RG_SEL,
    RG_STS,
    RG_IE,
    RG_CLR,
    RG_EN,
    RG_CAP
  } reg_grp_e;
endpackage

// File: rtl/mmt_sync.sv
module mmt_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/mmt_rst_sync.sv
module mmt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      rst_n_o <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_n_o <= stage_q;
    end
  end
endmodule

// File: rtl/mmt_counter.sv
module mmt_counter #(
  parameter int CW = 32,
  parameter int NM = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic [NM-1:0][CW-1:0]  match_val,
  input  logic [CW-1:0]          preload,
  input  logic [NM-1:0]          rld_sel,
  input  logic                   cap_tgl,
  output logic [CW-1:0]          cnt_o,
  output logic [CW-1:0]          snap_o,
  output logic [NM-1:0]          hit_tgl_o,
  output logic                   reload_o,
  output logic                   cap_stb_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] snap_q, snap_d;
  logic [NM-1:0] hit;
  logic [NM-1:0] tgl_q, tgl_d;
  logic          cap_s, cap_seen_q;
  logic          reload, cap_stb;

  mmt_sync #(.W(1)) cap_sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cap_tgl),
    .q     (cap_s)
  );

  for (genvar m = 0; m < NM; m++) begin : g_cmp
    assign hit[m] = run && (cnt_q == match_val[m]);
  end

  always_comb begin
    reload  = |(hit & rld_sel);
    cap_stb = cap_s ^ cap_seen_q;
    cnt_d   = cnt_q;
    if (run) begin
      cnt_d = reload ? preload : cnt_q + CW'(1);
    end
    tgl_d  = tgl_q ^ hit;
    snap_d = cap_stb ? cnt_q : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      snap_q     <= '0;
      tgl_q      <= '0;
      cap_seen_q <= 1'b0;
    end else begin
      if (run) cnt_q <= cnt_d;
      if (cap_stb) snap_q <= snap_d;
      tgl_q      <= tgl_d;
      cap_seen_q <= cap_s;
    end
  end

  assign cnt_o     = cnt_q;
  assign snap_o    = snap_q;
  assign hit_tgl_o = tgl_q;
  assign reload_o  = reload;
  assign cap_stb_o = cap_stb;
endmodule

// File: rtl/mmt_regs.sv
module mmt_regs
  import mmt_pkg::*;
#(
  parameter int NT  = 3,
  parameter int NM  = 3,
  parameter int CW  = 32,
  parameter int CKW = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sel,
  input  logic                        wr,
  input  logic [AW-1:0]               addr,
  input  logic [DW-1:0]               wdata,
  output logic [DW-1:0]               rdata,
  input  logic [NT-1:0][CW-1:0]       snap,
  input  logic [NT-1:0][NM-1:0]       evt_tgl,
  output logic [NT*NM-1:0][CW-1:0]    match_o,
  output logic [NT-1:0][CW-1:0]       pre_o,
  output logic [NT-1:0][NM-1:0]       rsel_o,
  output logic [NT-1:0]               en_o,
  output logic [NT-1:0]               cap_tgl_o,
  output logic [NT-1:0][NM-1:0]       sts_o,
  output logic [NT-1:0][NM-1:0]       evt_o,
  output logic [NT-1:0][NM-1:0]       clr_o,
  output logic [NT-1:0]               irq_o
);
  localparam int A_CLK   = 0;
  localparam int A_MATCH = 1;
  localparam int A_PRE   = A_MATCH + NT * NM;
  localparam int A_SEL   = A_PRE + NT;
  localparam int A_STS   = A_SEL + NT;
  localparam int A_IE    = A_STS + NT;
  localparam int A_CLR   = A_IE + NT;
  localparam int A_EN    = A_CLR + NT;
  localparam int A_CAP   = A_EN + 1;
  localparam int A_END   = A_CAP + NT;
  localparam int IW      = $clog2(NT * NM + 1);

  reg_grp_e      grp;
  logic [AW-1:0] off;
  logic [IW-1:0] idx;
  logic          wr_en;

  logic [CKW-1:0]              clk_q, clk_d;
  logic [NT*NM-1:0][CW-1:0]    match_q, match_d;
  logic [NT-1:0][CW-1:0]       pre_q, pre_d;
  logic [NT-1:0][NM-1:0]       rsel_q, rsel_d;
  logic [NT-1:0][NM-1:0]       ie_q, ie_d;
  logic [NT-1:0][NM-1:0]       sts_q, sts_d;
  logic [NT-1:0][NM-1:0]       evt_prev_q, evt, clr;
  logic [NT-1:0]               en_q, en_d;
  logic [NT-1:0]               cap_q, cap_d;

  // address decode
  always_comb begin
    grp = RG_NONE;
    off = '0;
    if (addr == AW'(A_CLK)) begin
      grp = RG_CLK;
    end else if (addr < AW'(A_PRE)) begin
      grp = RG_MATCH;
      off = addr - AW'(A_MATCH);
    end else if (addr < AW'(A_SEL)) begin
      grp = RG_PRE;
      off = addr - AW'(A_PRE);
    end else if (addr < AW'(A_STS)) begin
      grp = RG_SEL;
      off = addr - AW'(A_SEL);
    end else if (addr < AW'(A_IE)) begin
      grp = RG_STS;
      off = addr - AW'(A_STS);
    end else if (addr < AW'(A_CLR)) begin
      grp = RG_IE;
      off = addr - AW'(A_IE);
    end else if (addr < AW'(A_EN)) begin
      grp = RG_CLR;
      off = addr - AW'(A_CLR);
    end else if (addr == AW'(A_EN)) begin
      grp = RG_EN;
    end else if (addr < AW'(A_END)) begin
      grp = RG_CAP;
      off = addr - AW'(A_CAP);
    end
    idx   = IW'(off);
    wr_en = sel && wr;
  end

  // next state
  always_comb begin
    clk_d   = clk_q;
    match_d = match_q;
    pre_d   = pre_q;
    rsel_d  = rsel_q;
    ie_d    = ie_q;
    en_d    = en_q;
    cap_d   = cap_q;
    clr     = '0;
    if (wr_en) begin
      case (grp)
        RG_CLK:   clk_d        = wdata[CKW-1:0];
        RG_MATCH: match_d[idx] = wdata[CW-1:0];
        RG_PRE:   pre_d[idx]   = wdata[CW-1:0];
        RG_SEL:   rsel_d[idx]  = wdata[NM-1:0];
        RG_IE:    ie_d[idx]    = wdata[NM-1:0];
        RG_CLR:   clr[idx]     = wdata[NM-1:0];
        RG_EN:    en_d         = wdata[NT-1:0];
        RG_CAP:   cap_d[idx]   = cap_q[idx] ^ wdata[0];
        default:  ;
      endcase
    end
    evt   = evt_tgl ^ evt_prev_q;
    sts_d = evt | (sts_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q      <= '0;
      match_q    <= '0;
      pre_q      <= '0;
      rsel_q     <= '0;
      ie_q       <= '0;
      en_q       <= '0;
      cap_q      <= '0;
      sts_q      <= '0;
      evt_prev_q <= '0;
    end else begin
      if (wr_en) begin
        clk_q   <= clk_d;
        match_q <= match_d;
        pre_q   <= pre_d;
        rsel_q  <= rsel_d;
        ie_q    <= ie_d;
        en_q    <= en_d;
        cap_q   <= cap_d;
      end
      sts_q      <= sts_d;
      evt_prev_q <= evt_tgl;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (sel) begin
      case (grp)
        RG_CLK:   rdata = DW'(clk_q);
        RG_MATCH: rdata = DW'(match_q[idx]);
        RG_PRE:   rdata = DW'(pre_q[idx]);
        RG_SEL:   rdata = DW'(rsel_q[idx]);
        RG_STS:   rdata = DW'(sts_q[idx]);
        RG_IE:    rdata = DW'(ie_q[idx]);
        RG_EN:    rdata = DW'(en_q);
        RG_CAP:   rdata = DW'(snap[idx]);
        default:  rdata = '0;
      endcase
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_irq
    assign irq_o[t] = |(sts_q[t] & ie_q[t]);
  end

  assign match_o   = match_q;
  assign pre_o     = pre_q;
  assign rsel_o    = rsel_q;
  assign en_o      = en_q;
  assign cap_tgl_o = cap_q;
  assign sts_o     = sts_q;
  assign evt_o     = evt;
  assign clr_o     = clr;
endmodule

// File: rtl/mmt_timer_bank.sv
module mmt_timer_bank
  import mmt_pkg::*;
#(
  parameter int NT  = 3,
  parameter int NM  = 3,
  parameter int CW  = 32,
  parameter int CKW = 8
) (
  input  logic             bus_clk,
  input  logic             fn_clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [NT*NM-1:0] match_status,
  output logic [NT-1:0]    irq
);
  logic bus_rst_q, fn_rst_q;

  logic [NT*NM-1:0][CW-1:0] match_w;
  logic [NT-1:0][CW-1:0]    pre_w, cnt_w, snap_w;
  logic [NT-1:0][NM-1:0]    rsel_w, sts_w, evt_w, clr_w;
  logic [NT-1:0][NM-1:0]    hit_tgl_w, hit_tgl_s;
  logic [NT-1:0]            en_w, run_w, cap_tgl_w, reload_w, cap_stb_w;

  mmt_rst_sync bus_rst_i (.clk(bus_clk), .arst_n(rst_n), .rst_n_o(bus_rst_q));
  mmt_rst_sync fn_rst_i  (.clk(fn_clk),  .arst_n(rst_n), .rst_n_o(fn_rst_q));

  mmt_regs #(.NT(NT), .NM(NM), .CW(CW), .CKW(CKW)) regs_i (
    .clk       (bus_clk),
    .rst_n     (bus_rst_q),
    .sel       (bus_sel),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .snap      (snap_w),
    .evt_tgl   (hit_tgl_s),
    .match_o   (match_w),
    .pre_o     (pre_w),
    .rsel_o    (rsel_w),
    .en_o      (en_w),
    .cap_tgl_o (cap_tgl_w),
    .sts_o     (sts_w),
    .evt_o     (evt_w),
    .clr_o     (clr_w),
    .irq_o     (irq)
  );

  mmt_sync #(.W(NT)) en_sync_i (
    .clk(fn_clk), .rst_n(fn_rst_q), .d(en_w), .q(run_w)
  );

  mmt_sync #(.W(NT * NM)) hit_sync_i (
    .clk(bus_clk), .rst_n(bus_rst_q), .d(hit_tgl_w), .q(hit_tgl_s)
  );

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    mmt_counter #(.CW(CW), .NM(NM)) cnt_i (
      .clk       (fn_clk),
      .rst_n     (fn_rst_q),
      .run       (run_w[t]),
      .match_val (match_w[NM*t +: NM]),
      .preload   (pre_w[t]),
      .rld_sel   (rsel_w[t]),
      .cap_tgl   (cap_tgl_w[t]),
      .cnt_o     (cnt_w[t]),
      .snap_o    (snap_w[t]),
      .hit_tgl_o (hit_tgl_w[t]),
      .reload_o  (reload_w[t]),
      .cap_stb_o (cap_stb_w[t])
    );
  end

  assign match_status = sts_w;
endmodule

// File: rtl/mmt_checker.sv
module mmt_checker #(
  parameter int NT = 3,
  parameter int NM = 3,
  parameter int CW = 32
) (
  input logic                  bus_clk,
  input logic                  fn_clk,
  input logic                  bus_rst_n,
  input logic                  fn_rst_n,
  input logic [NT-1:0][CW-1:0] cnt,
  input logic [NT-1:0][CW-1:0] snap,
  input logic [NT-1:0][CW-1:0] pre,
  input logic [NT-1:0]         run,
  input logic [NT-1:0]         reload,
  input logic [NT-1:0]         cap_stb,
  input logic [NT-1:0][NM-1:0] evt,
  input logic [NT-1:0][NM-1:0] clr,
  input logic [NT-1:0][NM-1:0] sts
);
  for (genvar t = 0; t < NT; t++) begin : g_t
    a_r3_stopped_holds: assert property (@(posedge fn_clk) disable iff (!fn_rst_n)
      !run[t] |=> $stable(cnt[t]));

    a_r4_single_step: assert property (@(posedge fn_clk) disable iff (!fn_rst_n)
      (run[t] && !reload[t]) |=> (cnt[t] == $past(cnt[t]) + CW'(1)));

    a_r6_reload_loads: assert property (@(posedge fn_clk) disable iff (!fn_rst_n)
      (run[t] && reload[t]) |=> (cnt[t] == $past(pre[t])));

    a_r8_snap_frozen: assert property (@(posedge fn_clk) disable iff (!fn_rst_n)
      !cap_stb[t] |=> $stable(snap[t]));

    for (genvar m = 0; m < NM; m++) begin : g_m
      a_r5_set_needs_hit: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(sts[t][m]) |-> $past(evt[t][m]));

      a_r10_hit_wins: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (evt[t][m] && clr[t][m]) |=> sts[t][m]);

      a_r10_clear_works: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (clr[t][m] && !evt[t][m]) |=> !sts[t][m]);
    end
  end
endmodule

bind mmt_timer_bank mmt_checker #(.NT(NT), .NM(NM), .CW(CW)) chk_i (
  .bus_clk   (bus_clk),
  .fn_clk    (fn_clk),
  .bus_rst_n (bus_rst_q),
  .fn_rst_n  (fn_rst_q),
  .cnt       (cnt_w),
  .snap      (snap_w),
  .pre       (pre_w),
  .run       (run_w),
  .reload    (reload_w),
  .cap_stb   (cap_stb_w),
  .evt       (evt_w),
  .clr       (clr_w),
  .sts       (sts_w)
);

// File: tb/mmt_timer_bank_tb_top.sv
module mmt_timer_bank_tb_top;
  localparam int A_CLK = 0, A_MATCH = 1, A_PRE = 10, A_SEL = 13, A_STS = 16;
  localparam int A_IE = 19, A_CLR = 22, A_EN = 25, A_CAP = 26;
  localparam int NV = 13;

  // {address, write data, expected readback}
  localparam logic [69:0] VEC [NV] = '{
    {6'd0,  32'hFFFF_FFFF, 32'h0000_00FF},
    {6'd1,  32'h0000_0003, 32'h0000_0003},
    {6'd2,  32'h0000_0007, 32'h0000_0007},
    {6'd3,  32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {6'd5,  32'h0000_0006, 32'h0000_0006},
    {6'd7,  32'h0000_0005, 32'h0000_0005},
    {6'd10, 32'h0000_000A, 32'h0000_000A},
    {6'd11, 32'h0000_0004, 32'h0000_0004},
    {6'd13, 32'hFFFF_FFF9, 32'h0000_0001},
    {6'd14, 32'h0000_0002, 32'h0000_0002},
    {6'd19, 32'hFFFF_FFF8, 32'h0000_0000},
    {6'd22, 32'h0000_0007, 32'h0000_0000},
    {6'd25, 32'hFFFF_FFF8, 32'h0000_0000}
  };

  logic        bus_clk = 1'b0;
  logic        fn_clk  = 1'b0;
  logic        rst_n   = 1'b0;
  logic        sel     = 1'b0;
  logic        wr      = 1'b0;
  logic [5:0]  addr    = '0;
  logic [31:0] wdata   = '0;
  logic [31:0] rdata;
  logic [8:0]  mst;
  logic [2:0]  irq;

  int bus_cyc = 0;
  int n_chk   = 0;
  int n_bad   = 0;

  always #10 bus_clk = ~bus_clk;
  always #40 fn_clk  = ~fn_clk;
  always @(posedge bus_clk) bus_cyc <= bus_cyc + 1;

  mmt_timer_bank dut_i (
    .bus_clk      (bus_clk),
    .fn_clk       (fn_clk),
    .rst_n        (rst_n),
    .bus_sel      (sel),
    .bus_wr       (wr),
    .bus_addr     (addr),
    .bus_wdata    (wdata),
    .bus_rdata    (rdata),
    .match_status (mst),
    .irq          (irq)
  );

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic chk_rng(input string rq, input logic [31:0] got,
                         input logic [31:0] lo, input logic [31:0] hi);
    n_chk++;
    if (got < lo || got > hi) begin
      n_bad++;
      $display("FAIL %s: got %h expected within %h..%h", rq, got, lo, hi);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge bus_clk);
    sel = 1'b1; wr = 1'b1; addr = 6'(a); wdata = d;
    @(negedge bus_clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    @(negedge bus_clk);
    sel = 1'b1; wr = 1'b0; addr = 6'(a);
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic snap_rd(input int t, output logic [31:0] d);
    wr_reg(A_CAP + t, 32'h1);
    wait_cyc(40);
    rd_reg(A_CAP + t, d);
  endtask

  task automatic align4();
    do @(negedge bus_clk); while (bus_cyc % 4 != 0);
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, v1, v2, va, vb;
    int sa, sb;

    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(12);

    // R1: reset state
    rd_reg(A_CLK, d);      chk("R1 clkctl", d, 32'h0);
    rd_reg(A_EN, d);       chk("R1 enable", d, 32'h0);
    rd_reg(A_STS + 1, d);  chk("R1 status", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    snap_rd(0, d);         chk("R1 count", d, 32'h0);

    // R2: register table
    for (int i = 0; i < NV; i++) begin
      wr_reg(int'(VEC[i][69:64]), VEC[i][63:32]);
      rd_reg(int'(VEC[i][69:64]), d);
      chk("R2 readback", d, VEC[i][31:0]);
    end

    // run timers 0 and 1
    wr_reg(A_EN, 32'h3);
    wait_cyc(240);

    rd_reg(A_STS + 0, d);  chk("R5 R6 t0 status", d, 32'h1);
    rd_reg(A_STS + 1, d);  chk("R5 t1 status", d, 32'h7);
    rd_reg(A_STS + 2, d);  chk("R3 t2 status", d, 32'h0);
    chk("R9 match_status", 32'(mst), 32'h039);
    chk("R9 irq masked", 32'(irq), 32'h0);

    snap_rd(1, d);         chk_rng("R6 t1 loop", d, 32'd4, 32'd6);
    snap_rd(2, d);         chk("R3 t2 stopped", d, 32'h0);

    // R7: stale read then fresh
    snap_rd(0, v1);        chk_rng("R6 t0 skipped", v1, 32'd10, 32'd1000);
    wr_reg(A_CAP + 0, 32'h1);
    rd_reg(A_CAP + 0, d);  chk("R7 previous", d, v1);
    wait_cyc(40);
    rd_reg(A_CAP + 0, v2);
    chk("R7 updated", 32'(v2 > v1), 32'h1);

    // R4: exact rate between equal-phase requests
    align4(); sa = bus_cyc;
    wr_reg(A_CAP + 0, 32'h1); wait_cyc(40); rd_reg(A_CAP + 0, va);
    wait_cyc(57);
    align4(); sb = bus_cyc;
    wr_reg(A_CAP + 0, 32'h1); wait_cyc(40); rd_reg(A_CAP + 0, vb);
    chk("R4 rate", vb - va, 32'((sb - sa) / 4));

    // R3: disabled timer holds
    wr_reg(A_EN, 32'h2);
    wait_cyc(20);
    snap_rd(0, v1);
    wait_cyc(100);
    snap_rd(0, v2);
    chk("R3 hold", v2, v1);

    // R8: snapshot frozen while timer 1 runs
    rd_reg(A_CAP + 1, v1);
    wait_cyc(100);
    rd_reg(A_CAP + 1, v2);
    chk("R8 frozen", v2, v1);

    // R9: interrupt enables
    wr_reg(A_IE + 1, 32'h2);
    wait_cyc(2);
    chk("R9 irq t1", 32'(irq), 32'h2);
    wr_reg(A_IE + 0, 32'h1);
    wait_cyc(2);
    chk("R9 irq t0 t1", 32'(irq), 32'h3);

    // R10: clears
    wr_reg(A_CLR + 0, 32'h1);
    rd_reg(A_STS + 0, d);  chk("R10 clear t0", d, 32'h0);
    chk("R10 irq t0 low", 32'(irq[0]), 32'h0);
    wr_reg(A_EN, 32'h0);
    wait_cyc(40);
    wr_reg(A_CLR + 1, 32'h7);
    rd_reg(A_STS + 1, d);  chk("R10 clear t1", d, 32'h0);
    chk("R10 irq low", 32'(irq), 32'h0);

    // R6: no selection, count passes its match values
    wr_reg(A_EN, 32'h4);
    wait_cyc(200);
    snap_rd(2, d);         chk_rng("R6 t2 no reload", d, 32'd6, 32'd1000);
    rd_reg(A_STS + 2, d);  chk("R5 t2 status", d, 32'h7);

    // R1: reset again
    @(negedge bus_clk);
    rst_n = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(12);
    rd_reg(A_EN, d);       chk("R1 enable after reset", d, 32'h0);
    chk("R1 match_status after reset", 32'(mst), 32'h0);
    snap_rd(2, d);         chk("R1 count after reset", d, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule